// File: doc/BRIEF.md
# Descriptor Ring Memory Copy Engine

This block copies blocks of 32-bit words from one memory region to another. The work comes from a ring of transfer descriptors that lives in main memory. Software programs where the ring starts and how many slots it holds. It fills descriptor slots and then moves a tail index forward. The engine compares its own head index with that tail. While the two differ, it fetches the descriptor at the head and copies the requested number of words. It then steps the head forward, wrapping at the ring size.

More work can be queued at any time by writing further descriptors and moving the tail again. No restart is needed. When head and tail become equal the engine goes quiet by itself. Completion is reported through two sticky status bits, each of which can drive the interrupt line. One bit means "a descriptor that asked for notice has finished". The other means "the ring has drained".

Top module: `desc_ring_dma`

## Requirements
- R1: While the head index equals the tail index (or the ring size is 0), the engine issues no memory request and stays idle.
- R2: A descriptor copies `len` words: the word at source+k goes to destination+k for k = 0..len-1, in increasing order, one read then one write per word. The word at destination+len is left untouched. Addresses are word addresses.
- R3: Descriptor n occupies three words at base + 3*n: source address, destination address, then a control word with the length in bits 15:0 and the notify flag in bit 31.
- R4: The head index (register 2, read only) steps by one only after the last data write of a descriptor has completed. It wraps to 0 when the step would reach the ring size (register 1).
- R5: Status bit 0 (register 5) is set when a descriptor whose notify flag is 1 finishes. A descriptor whose flag is 0 leaves it unchanged.
- R6: A descriptor with length 0 performs no data read or write, yet still advances the head and honours its notify flag.
- R7: Status bit 1 is set when, on finishing a descriptor, the new head equals the tail.
- R8: Writing 1 to a status bit clears it; writing 0 leaves it. The irq output is high exactly when a status bit is set and its enable bit in register 4 (bit 0 for done, bit 1 for drained) is 1.
- R9: Software may write new descriptors and move the tail (register 3) while a copy is in progress. The engine picks up the new entries without any restart.
- R10: After reset the head, tail, status and irq are 0 and no memory request is active. Register 0 holds the ring base address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = write access, 0 = read access |
| mem_addr | output | 32 | Word address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes in this cycle |
| mem_rdata | input | 32 | Read data, valid while mem_ack is high on a read |
| irq | output | 1 | Interrupt request |

## Verification
A wrong head index shows up within a single descriptor. The fetch lands on the wrong slot, the copied data lands in the wrong place, and the HEAD register read back after the drain does not match the expected wrap position. A mistaken copy counter corrupts the word just past the destination block, or changes the number of writes. Both are visible as soon as that descriptor retires. Faulty status or enable logic is seen on the irq pin in the cycle after the status write that should have changed it. An engine that ignores head and tail either hangs on an appended entry, which the bench catches while polling, or keeps requesting memory while the ring is empty.

// File: rtl/dmr_pkg.sv
package dmr_pkg;

    localparam int WORD_W       = 32;
    localparam int LEN_W        = 16;
    localparam int DESC_WORDS   = 3;
    localparam int NOTIFY_BIT   = 31;
    localparam int REG_SEL_W    = 3;

    typedef enum logic [REG_SEL_W-1:0] {
        RG_BASE  = 3'd0,
        RG_SIZE  = 3'd1,
        RG_HEAD  = 3'd2,
        RG_TAIL  = 3'd3,
        RG_IRQEN = 3'd4,
        RG_STAT  = 3'd5
    } reg_sel_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_READ,
        ST_WRITE,
        ST_RETIRE
    } eng_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] src;
        logic [WORD_W-1:0] dst;
        logic              notify;
        logic [LEN_W-1:0]  len;
    } xfer_desc_t;

    typedef struct packed {
        logic drained;
        logic done;
    } irq_bits_t;

    // Word address of word 'w' inside ring slot 'idx'.
    function automatic logic [WORD_W-1:0] slot_word_addr(
        input logic [WORD_W-1:0] base,
        input logic [WORD_W-1:0] idx,
        input logic [1:0]        w
    );
        return base + idx * WORD_W'(DESC_WORDS) + WORD_W'(w);
    endfunction

endpackage

// File: rtl/dmr_head.sv
module dmr_head
    import dmr_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic [IDX_W-1:0] size,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] head_next
);

    localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

    logic [IDX_W:0] bumped;

    always_comb begin
        bumped    = {1'b0, head} + {1'b0, ONE};
        head_next = (bumped >= {1'b0, size}) ? '0 : bumped[IDX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            head <= '0;
        else if (adv)
            head <= head_next;
    end

endmodule

// File: rtl/dmr_regs.sv
module dmr_regs
    import dmr_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [REG_SEL_W-1:0] addr,
    input  logic [WORD_W-1:0]    wdata,
    output logic [WORD_W-1:0]    rdata,
    input  logic [IDX_W-1:0]     head,
    input  logic                 done_set,
    input  logic                 drained_set,
    output logic [WORD_W-1:0]    base,
    output logic [IDX_W-1:0]     size,
    output logic [IDX_W-1:0]     tail,
    output logic                 irq
);

    irq_bits_t enable_q;
    irq_bits_t status_q;
    irq_bits_t clear_req;
    reg_sel_e  sel;

    assign sel = reg_sel_e'(addr);

    always_comb begin
        clear_req = '0;
        if (we && sel == RG_STAT) begin
            clear_req.done    = wdata[0];
            clear_req.drained = wdata[1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base     <= '0;
            size     <= '0;
            tail     <= '0;
            enable_q <= '0;
        end else if (we) begin
            case (sel)
                RG_BASE:  base     <= wdata;
                RG_SIZE:  size     <= wdata[IDX_W-1:0];
                RG_TAIL:  tail     <= wdata[IDX_W-1:0];
                RG_IRQEN: enable_q <= '{drained: wdata[1], done: wdata[0]};
                default:  ;
            endcase
        end
    end

    // Set events win over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
        end else begin
            status_q.done    <= done_set    | (status_q.done    & ~clear_req.done);
            status_q.drained <= drained_set | (status_q.drained & ~clear_req.drained);
        end
    end

    assign irq = |(status_q & enable_q);

    always_comb begin
        case (sel)
            RG_BASE:  rdata = base;
            RG_SIZE:  rdata = WORD_W'(size);
            RG_HEAD:  rdata = WORD_W'(head);
            RG_TAIL:  rdata = WORD_W'(tail);
            RG_IRQEN: rdata = WORD_W'(enable_q);
            RG_STAT:  rdata = WORD_W'(status_q);
            default:  rdata = '0;
        endcase
    end

    // R8: a write of 1 clears the done bit unless a new completion arrives.
    p_w1c_done_r8: assert property (@(posedge clk) disable iff (rst)
        (we && sel == RG_STAT && wdata[0] && !done_set) |=> !status_q.done);

    // R8: a write of 0 keeps a set drained bit.
    p_keep_drained_r8: assert property (@(posedge clk) disable iff (rst)
        (status_q.drained && !(we && sel == RG_STAT && wdata[1])) |=> status_q.drained);

endmodule

// File: rtl/dmr_engine.sv
module dmr_engine
    import dmr_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] base,
    input  logic [IDX_W-1:0]  size,
    input  logic [IDX_W-1:0]  head,
    input  logic [IDX_W-1:0]  head_next,
    input  logic [IDX_W-1:0]  tail,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              adv,
    output logic              done_evt,
    output logic              drained_evt
);

    localparam logic [1:0] LAST_WORD = 2'(DESC_WORDS - 1);

    eng_state_e        state;
    logic [1:0]        widx;
    logic [LEN_W-1:0]  cnt;
    xfer_desc_t        desc;
    logic [WORD_W-1:0] data_buf;
    logic              ring_busy;
    logic              last_copy;

    assign ring_busy = (size != '0) && ((head ^ tail) != '0);
    assign last_copy = (cnt == desc.len - LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            widx     <= '0;
            cnt      <= '0;
            desc     <= '0;
            data_buf <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    widx <= '0;
                    if (ring_busy) state <= ST_FETCH;
                end
                ST_FETCH: if (mem_ack) begin
                    case (widx)
                        2'd0:    desc.src <= mem_rdata;
                        2'd1:    desc.dst <= mem_rdata;
                        default: begin
                            desc.len    <= mem_rdata[LEN_W-1:0];
                            desc.notify <= mem_rdata[NOTIFY_BIT];
                        end
                    endcase
                    if (widx == LAST_WORD) begin
                        cnt   <= '0;
                        state <= (mem_rdata[LEN_W-1:0] == '0) ? ST_RETIRE : ST_READ;
                    end else begin
                        widx <= widx + 2'd1;
                    end
                end
                ST_READ: if (mem_ack) begin
                    data_buf <= mem_rdata;
                    state    <= ST_WRITE;
                end
                ST_WRITE: if (mem_ack) begin
                    if (last_copy) begin
                        state <= ST_RETIRE;
                    end else begin
                        cnt   <= cnt + LEN_W'(1);
                        state <= ST_READ;
                    end
                end
                ST_RETIRE: state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        mem_addr = '0;
        case (state)
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = slot_word_addr(base, WORD_W'(head), widx);
            end
            ST_READ: begin
                mem_req  = 1'b1;
                mem_addr = desc.src + WORD_W'(cnt);
            end
            ST_WRITE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = desc.dst + WORD_W'(cnt);
            end
            default: ;
        endcase
    end

    assign mem_wdata   = data_buf;
    assign adv         = (state == ST_RETIRE);
    assign done_evt    = adv && desc.notify;
    assign drained_evt = adv && (head_next == tail);

    // R1: an empty ring keeps the memory port quiet.
    p_idle_empty_r1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && head == tail) |=> !mem_req);

    // R2: a pending access keeps its address and direction until acknowledged.
    p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R6: a zero-length descriptor makes no data access after its fetch.
    p_zero_len_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH && mem_ack && widx == LAST_WORD &&
         mem_rdata[LEN_W-1:0] == '0) |=> !mem_req);

    // R4: retiring lasts exactly one cycle.
    p_single_retire_r4: assert property (@(posedge clk) disable iff (rst)
        adv |=> !adv);

endmodule

// File: rtl/desc_ring_dma.sv
module desc_ring_dma
    import dmr_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_we,
    input  logic [REG_SEL_W-1:0] reg_addr,
    input  logic [WORD_W-1:0]    reg_wdata,
    output logic [WORD_W-1:0]    reg_rdata,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [WORD_W-1:0]    mem_addr,
    output logic [WORD_W-1:0]    mem_wdata,
    input  logic                 mem_ack,
    input  logic [WORD_W-1:0]    mem_rdata,
    output logic                 irq
);

    logic [WORD_W-1:0] ring_base;
    logic [IDX_W-1:0]  ring_size;
    logic [IDX_W-1:0]  ring_tail;
    logic [IDX_W-1:0]  ring_head;
    logic [IDX_W-1:0]  ring_head_next;
    logic              step;
    logic              done_evt;
    logic              drained_evt;

    dmr_regs #(.IDX_W(IDX_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .we          (reg_we),
        .addr        (reg_addr),
        .wdata       (reg_wdata),
        .rdata       (reg_rdata),
        .head        (ring_head),
        .done_set    (done_evt),
        .drained_set (drained_evt),
        .base        (ring_base),
        .size        (ring_size),
        .tail        (ring_tail),
        .irq         (irq)
    );

    dmr_head #(.IDX_W(IDX_W)) u_head (
        .clk       (clk),
        .rst       (rst),
        .adv       (step),
        .size      (ring_size),
        .head      (ring_head),
        .head_next (ring_head_next)
    );

    dmr_engine #(.IDX_W(IDX_W)) u_engine (
        .clk         (clk),
        .rst         (rst),
        .base        (ring_base),
        .size        (ring_size),
        .head        (ring_head),
        .head_next   (ring_head_next),
        .tail        (ring_tail),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_ack     (mem_ack),
        .mem_rdata   (mem_rdata),
        .adv         (step),
        .done_evt    (done_evt),
        .drained_evt (drained_evt)
    );

    // R4: the head only moves in the cycle after the engine retires a descriptor.
    p_head_moves_on_retire_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(ring_head) |-> $past(step));

    // R4: no head movement while a data write is still pending.
    p_no_step_in_flight_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && !mem_ack) |=> $stable(ring_head));

endmodule

// File: tb/test_desc_ring_dma.sv
`timescale 1ns/1ps
module test_desc_ring_dma;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        irq;

    always #2.5 clk = ~clk;

    desc_ring_dma i_desc_ring_dma (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .irq(irq)
    );

    // Memory model: acknowledges one cycle after a request is seen.
    logic [31:0] mem [1024];
    logic        ack_q;
    int          n_wr = 0;
    int          n_req = 0;

    always @(posedge clk) begin
        if (rst) begin
            ack_q <= 1'b0;
        end else begin
            ack_q <= mem_req && !ack_q;
            if (mem_req) n_req <= n_req + 1;
            if (mem_req && ack_q && mem_we) begin
                mem[mem_addr[9:0]] <= mem_wdata;
                n_wr <= n_wr + 1;
            end
        end
    end
    assign mem_ack   = ack_q;
    assign mem_rdata = mem[mem_addr[9:0]];

    int total = 0;
    int bad   = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_head(input int exp);
        logic [31:0] h;
        for (int k = 0; k < 4000; k++) begin
            rd(3'd2, h);
            if (h == 32'(exp)) break;
        end
    endtask

    localparam int BASE = 16;
    localparam int SIZE = 4;

    task automatic put_desc(input int slot, input int src, input int dst,
                            input int len, input bit flag);
        mem[BASE + 3*slot]     = 32'(src);
        mem[BASE + 3*slot + 1] = 32'(dst);
        mem[BASE + 3*slot + 2] = {flag, 15'd0, 16'(len)};
    endtask

    task automatic fill(input int src, input int dst, input int len, input int tag);
        for (int k = 0; k <= len; k++) begin
            mem[src + k] = 32'hC0DE_0000 + 32'(tag * 256 + k);
            mem[dst + k] = 32'h5A5A_0000 + 32'(k);
        end
    endtask

    task automatic check_copy(input int src, input int dst, input int len, input string req);
        int errs = 0;
        for (int k = 0; k < len; k++)
            if (mem[dst + k] !== mem[src + k]) errs++;
        chk(errs == 0, req, "copied words mismatched", errs, 0);
        chk(mem[dst + len] == 32'h5A5A_0000 + 32'(len), "R2", "word past block",
            mem[dst + len], 32'h5A5A_0000 + 32'(len));
    endtask

    // {src[48:33], dst[32:17], len[16:1], notify[0]}
    localparam logic [48:0] VEC [6] = '{
        {16'd100, 16'd300, 16'd4, 1'b1},
        {16'd120, 16'd320, 16'd1, 1'b0},
        {16'd140, 16'd340, 16'd7, 1'b1},
        {16'd160, 16'd360, 16'd0, 1'b1},
        {16'd180, 16'd380, 16'd3, 1'b0},
        {16'd200, 16'd400, 16'd2, 1'b1}
    };

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        for (int k = 0; k < 1024; k++) mem[k] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10 reset state
        rd(3'd2, v); chk(v == 0, "R10", "head after reset", v, 0);
        rd(3'd3, v); chk(v == 0, "R10", "tail after reset", v, 0);
        rd(3'd5, v); chk(v == 0, "R10", "status after reset", v, 0);
        chk(irq == 1'b0, "R10", "irq after reset", irq, 0);
        chk(mem_req == 1'b0, "R10", "mem_req after reset", mem_req, 0);

        wr(3'd0, 32'(BASE));
        wr(3'd1, 32'(SIZE));
        rd(3'd0, v); chk(v == BASE, "R10", "base register", v, BASE);

        // Vector walk: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < 6; i++) begin
            int src, dst, len, slot, nxt, w0;
            bit flag;
            src  = int'(VEC[i][48:33]);
            dst  = int'(VEC[i][32:17]);
            len  = int'(VEC[i][16:1]);
            flag = VEC[i][0];
            slot = i % SIZE;
            nxt  = (i + 1) % SIZE;
            wr(3'd5, 32'h3);
            @(negedge clk);
            fill(src, dst, len, i);
            put_desc(slot, src, dst, len, flag);
            w0 = n_wr;
            wr(3'd3, 32'(nxt));
            wait_head(nxt);
            repeat (2) @(negedge clk);
            rd(3'd2, v); chk(v == 32'(nxt), "R4", "head after descriptor", v, nxt);
            check_copy(src, dst, len, "R3");
            chk(n_wr - w0 == len, "R6", "data write count", n_wr - w0, len);
            rd(3'd5, v);
            chk(v[0] == flag, "R5", "done status vs notify flag", v[0], flag);
            chk(v[1] == 1'b1, "R7", "drained status", v[1], 1);
        end

        // R1: empty ring, no requests
        begin
            int r0;
            r0 = n_req;
            repeat (30) @(negedge clk);
            chk(n_req == r0, "R1", "requests while empty", n_req - r0, 0);
        end

        // R8: status/enable/irq. Status now done=1 drained=1.
        chk(irq == 1'b0, "R8", "irq with no enables", irq, 0);
        wr(3'd4, 32'h2);
        #1 chk(irq == 1'b1, "R8", "irq drained enabled", irq, 1);
        wr(3'd5, 32'h2);
        #1 chk(irq == 1'b0, "R8", "irq after drained clear", irq, 0);
        rd(3'd5, v); chk(v == 32'h1, "R8", "done kept on write 0", v, 1);
        wr(3'd5, 32'h1);
        rd(3'd5, v); chk(v == 32'h0, "R8", "done cleared", v, 0);
        wr(3'd4, 32'h1);

        // R9: append while a long copy is running (head = 2)
        fill(500, 600, 20, 40);
        fill(540, 640, 5, 41);
        put_desc(2, 500, 600, 20, 1'b0);
        wr(3'd3, 32'd3);
        repeat (8) @(negedge clk);
        rd(3'd2, v); chk(v == 32'd2, "R4", "head held mid-copy", v, 2);
        put_desc(3, 540, 640, 5, 1'b1);
        wr(3'd3, 32'd0);
        wait_head(0);
        repeat (2) @(negedge clk);
        rd(3'd2, v); chk(v == 32'd0, "R9", "head after appended work", v, 0);
        check_copy(500, 600, 20, "R9");
        check_copy(540, 640, 5, "R9");
        chk(irq == 1'b1, "R8", "irq from done", irq, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule